// File: doc/BRIEF.md
# Mailbox Interrupt Flag Logic

This block raises and clears the port-to-port interrupts of a two-port shared memory. Two reserved words sit at the top of the address space. The topmost word is the right port's mailbox, and the word just below it is the left port's mailbox. When one port writes into the other port's mailbox, the owner's active-low interrupt goes low. The owner clears the interrupt by reading its own mailbox. The message data is kept in the shared memory and is not stored here.

Each port presents an enable, a write strobe, a read strobe, an address and the busy indication that the arbiter returns to it. The block watches these access signals in every clock cycle. A port that is told it is busy loses the contended access, so it neither sets the peer's interrupt nor clears its own. Both interrupt outputs come straight from registers.

Top module: `mbx_irq`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, both interrupt outputs are high (deasserted).
- R2: A left-port write (enable=1, write=1) to the all-ones address with left busy low drives the right interrupt low from the next clock edge.
- R3: A right-port write to the all-ones-minus-one address with right busy low drives the left interrupt low from the next clock edge.
- R4: A right-port read (enable=1, read=1, write=0) of the all-ones address with right busy low drives the right interrupt high from the next clock edge.
- R5: A left-port read of the all-ones-minus-one address with left busy low drives the left interrupt high from the next clock edge.
- R6: Reads of the peer's mailbox by either port leave both interrupts unchanged.
- R7: A write to the peer's mailbox while the writing port's busy is high leaves the peer's interrupt unchanged.
- R8: A read of its own mailbox while the reading port's busy is high leaves that port's interrupt unchanged.
- R9: When the same interrupt is set and cleared in one cycle, it ends low (set wins).
- R10: Accesses with enable low, accesses to any address outside the two mailboxes, and writes to a port's own mailbox leave both interrupts unchanged.
- R11: When write and read are both high on an enabled port, the access is a write only. It can set the peer's interrupt, but it never clears the port's own interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port lost arbitration this cycle |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port lost arbitration this cycle |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every set or clear is due exactly one clock edge after the cycle in which the access is presented. There is a single register between the access inputs and the outputs. The bench applies each access pattern on a falling edge and lets one rising edge pass. It then compares both outputs at the following falling edge against a bench model that has been stepped once for that edge. This means a check can never read a value from a cycle too early or too late. The reset check is made the same way: it samples one falling edge after a reset edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Port index convention used throughout the block.
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
  localparam int unsigned NPORT  = 2;

  // Kind of access seen on a port in one cycle.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic en, input logic wr, input logic rd);
    if (en && wr)      return ACC_WRITE;
    else if (en && rd) return ACC_READ;
    else               return ACC_IDLE;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              en,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              post_peer,
  output logic              take_own
);
  acc_kind_e kind;
  logic      granted;

  always_comb begin
    kind      = classify(en, wr, rd);
    granted   = !busy;
    post_peer = granted && (kind == ACC_WRITE) && (addr == PEER_BOX);
    take_own  = granted && (kind == ACC_READ)  && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)      irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic [NPORT-1:0]  en_v, wr_v, rd_v, busy_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [NPORT-1:0]  post_peer, take_own, irq_v;

  always_comb begin
    en_v   = {r_en, l_en};
    wr_v   = {r_wr, l_wr};
    rd_v   = {r_rd, l_rd};
    busy_v = {r_busy, l_busy};
    addr_v[PORT_L] = l_addr;
    addr_v[PORT_R] = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == PORT_R) ? BOX_R : BOX_L;
    localparam logic [ADDR_W-1:0] PEER = (p == PORT_R) ? BOX_L : BOX_R;

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .en       (en_v[p]),
      .wr       (wr_v[p]),
      .rd       (rd_v[p]),
      .addr     (addr_v[p]),
      .busy     (busy_v[p]),
      .post_peer(post_peer[p]),
      .take_own (take_own[p])
    );

    mbx_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (post_peer[NPORT-1-p]),
      .clr  (take_own[p]),
      .irq_n(irq_v[p])
    );
  end

  assign l_irq_n = irq_v[PORT_L];
  assign r_irq_n = irq_v[PORT_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              l_en,
  input logic              l_wr,
  input logic              l_rd,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy,
  input logic              r_en,
  input logic              r_wr,
  input logic              r_rd,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SUB = TOP - 1'b1;

  logic l_w, r_w, l_r, r_r;
  assign l_w = l_en && l_wr;
  assign r_w = r_en && r_wr;
  assign l_r = l_en && l_rd && !l_wr;
  assign r_r = r_en && r_rd && !r_wr;

  p_reset_high_r1: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n));

  p_set_right_r2: assert property (@(posedge clk) disable iff (rst)
    (l_w && l_addr == TOP && !l_busy) |=> !r_irq_n);

  p_set_left_r3: assert property (@(posedge clk) disable iff (rst)
    (r_w && r_addr == SUB && !r_busy) |=> !l_irq_n);

  p_clr_right_r4: assert property (@(posedge clk) disable iff (rst)
    (r_r && r_addr == TOP && !r_busy && !(l_w && l_addr == TOP && !l_busy)) |=> r_irq_n);

  p_clr_left_r5: assert property (@(posedge clk) disable iff (rst)
    (l_r && l_addr == SUB && !l_busy && !(r_w && r_addr == SUB && !r_busy)) |=> l_irq_n);

  // R7 and R8: with both ports busy, no flag may move.
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (l_busy && r_busy) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  // R10: idle ports leave both flags alone.
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!l_en && !r_en) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  // R6: peer-mailbox reads only on both sides change nothing.
  p_cross_read_r6: assert property (@(posedge clk) disable iff (rst)
    (l_r && l_addr == TOP && r_r && r_addr == SUB) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_bench.sv
module mbx_irq_bench;
  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] SUB = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en = 0, l_wr = 0, l_rd = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_rd = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  logic exp_l = 1'b1, exp_r = 1'b1;
  int   n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u_mbx_irq (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  function automatic logic next_n(input logic cur, input logic set, input logic clr);
    return set ? 1'b0 : (clr ? 1'b1 : cur);
  endfunction

  function automatic string auto_tag(input logic set, input logic clr, input string s, input string c);
    return set ? s : (clr ? c : "R10");
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Apply one cycle of access, step the model at the edge, compare one half-cycle later.
  task automatic step(input logic le, lw, lr, input logic [AW-1:0] la, input logic lb,
                      input logic re, rw, rr, input logic [AW-1:0] ra, input logic rb,
                      input string tag);
    logic set_l, clr_l, set_r, clr_r;
    string tl, tr;
    l_en = le; l_wr = lw; l_rd = lr; l_addr = la; l_busy = lb;
    r_en = re; r_wr = rw; r_rd = rr; r_addr = ra; r_busy = rb;
    set_r = le && lw && la == TOP && !lb;
    set_l = re && rw && ra == SUB && !rb;
    clr_r = re && rr && !rw && ra == TOP && !rb;
    clr_l = le && lr && !lw && la == SUB && !lb;
    tl = (tag != "") ? tag : auto_tag(set_l, clr_l, "R3", "R5");
    tr = (tag != "") ? tag : auto_tag(set_r, clr_r, "R2", "R4");
    @(posedge clk);
    exp_l = next_n(exp_l, set_l, clr_l);
    exp_r = next_n(exp_r, set_r, clr_r);
    @(negedge clk);
    check(tl, l_irq_n, exp_l, "l_irq_n");
    check(tr, r_irq_n, exp_r, "r_irq_n");
  endtask

  task automatic idle(input string tag);
    step(0,0,0,'0,0, 0,0,0,'0,0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    exp_l = 1'b1; exp_r = 1'b1;
    @(negedge clk);
    check("R1", l_irq_n, 1'b1, "l_irq_n in reset");
    check("R1", r_irq_n, 1'b1, "r_irq_n in reset");
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    idle("R1");
    // Sets and clears
    step(1,1,0,TOP,0, 0,0,0,'0,0, "R2");
    step(0,0,0,'0,0, 1,1,0,SUB,0, "R3");
    // Cross reads change nothing
    step(1,0,1,TOP,0, 1,0,1,SUB,0, "R6");
    // Own-mailbox writes, disabled ports and other addresses
    step(1,1,0,SUB,0, 1,1,0,TOP,0, "R10");
    step(0,1,0,TOP,0, 0,1,0,SUB,0, "R10");
    step(1,1,1,TOP-2,0, 1,1,1,12'h0,0, "R10");
    // Busy blocks clear
    step(1,0,1,SUB,1, 1,0,1,TOP,1, "R8");
    // Clears
    step(0,0,0,'0,0, 1,0,1,TOP,0, "R4");
    step(1,0,1,SUB,0, 0,0,0,'0,0, "R5");
    // Busy blocks set
    step(1,1,0,TOP,1, 1,1,0,SUB,1, "R7");
    // Write+read together acts as write: sets peer, no own clear
    step(1,1,1,TOP,0, 0,0,0,'0,0, "R11");
    step(0,0,0,'0,0, 1,1,1,TOP,0, "R11");
    // Set and clear on the same flag in one cycle
    step(1,1,0,TOP,0, 1,0,1,TOP,0, "R9");
    step(1,0,1,SUB,0, 1,1,0,SUB,0, "R9");
    // Reset while both flags are low
    do_reset();
    idle("R1");
    // Random traffic biased toward the mailboxes
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] la, ra;
      int unsigned kl, kr;
      kl = $urandom % 4; kr = $urandom % 4;
      la = (kl == 0) ? TOP : (kl == 1) ? SUB : (kl == 2) ? (($urandom % 2) ? TOP : SUB) : AW'($urandom);
      ra = (kr == 0) ? TOP : (kr == 1) ? SUB : (kr == 2) ? (($urandom % 2) ? TOP : SUB) : AW'($urandom);
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, la, ($urandom % 4) == 0,
           ($urandom % 4) != 0, $urandom % 2, $urandom % 2, ra, ($urandom % 4) == 0, "");
    end
    summary();
    $finish;
  end
endmodule